// File: doc/BRIEF.md
# Transceiver PLL Power-Up and Reset Sequencer

This controller takes a serial-transceiver PLL from power-down to a trusted locked state. Out of reset it holds the PLL in power-down. It keeps it there until it has seen a run of reference-clock edges with no long gap between them. It then releases power-down and, in the same cycle, raises an active-high PLL reset. That reset is held for a parameterised number of reference-clock periods. The controller then enables the PLL's lock detector and waits for the lock indication.

The lock input is asynchronous. It is resynchronised, and it must stay high for a set number of consecutive system-clock cycles before the ready flag is raised. The time to lock depends on the PLL's bandwidth and frequency, so the wait has no fixed length. It is bounded only by a timeout. When the timeout expires, a sticky error flag is set and the reset pulse is issued again. If lock is lost while the controller reports ready, the ready flag drops and the sequence restarts at the reset pulse.

Top module: `pll_rst_seq`

## Requirements
- R1: While `rst_n` is low, `pll_pd` is 1 and `pll_rst`, `pll_lock_en`, `seq_ready` and `seq_err` are 0.
- R2: `pll_pd` stays high until REF_EDGES_MIN reference-clock edges have been seen, with no two consecutive edges more than REF_GAP_MAX system cycles apart. A gap longer than that restarts the edge count, and with no reference clock `pll_pd` stays high indefinitely.
- R3: `pll_pd` falls in the same cycle that `pll_rst` rises. The reset pulse always follows the release of power-down.
- R4: Each `pll_rst` pulse lasts at least RST_REF_CYC reference-clock periods and then ends by itself. A RST_REF_CYC of zero is treated as 1.
- R5: `pll_lock_en` is high only while waiting for lock or while ready. It is never high together with `pll_pd` or `pll_rst`.
- R6: `seq_ready` rises only after the synchronised lock has been high for LOCK_STABLE consecutive system cycles with `pll_lock_en` high. A low glitch on the lock input restarts that count.
- R7: If lock has not been stable within LOCK_TMO system cycles of the end of the reset pulse, `seq_err` is set and `pll_rst` is raised again.
- R8: `seq_err` stays set through the retries and clears when `seq_ready` is next raised.
- R9: If the synchronised lock falls while `seq_ready` is high, `seq_ready` clears on the next cycle and `pll_rst` is raised again, while `pll_pd` stays low.
- R10: `pll_pd` and `pll_rst` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| ref_clk | input | 1 | PLL reference clock, sampled for activity |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| pll_pd | output | 1 | PLL power-down, active high |
| pll_rst | output | 1 | PLL reset pulse, active high |
| pll_lock_en | output | 1 | Enable for the PLL lock detector |
| seq_ready | output | 1 | PLL locked and trusted |
| seq_err | output | 1 | Sticky lock-wait timeout flag |

## Verification
The main sequence is driven with lock arriving after several delays. A short delay, a medium delay and one just inside the timeout must all reach ready with no error. One delay lands just past the timeout: it shows the error being set and then cleared by a late lock on the retry. A lock that never comes shows the error staying set through the repeated reset pulses. Two reference-clock bursts separated by a long pause check that edge counting really requires consecutive edges. A lock glitch whose total high time exceeds the stable window, but whose high time is not consecutive, separates a consecutive-cycle filter from a cumulative one. A lock drop while ready checks the restart at the reset pulse rather than at power-down.

// File: rtl/pllseq_pkg.sv
`timescale 1ns/1ps
package pllseq_pkg;

  typedef enum logic [1:0] {
    SEQ_PWRDN = 2'd0,
    SEQ_RESET = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_READY = 2'd3
  } seq_state_e;

  // Bits needed to hold the values 0..n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // A zero pulse width is forced up to one reference period.
  function automatic int rst_cycles_eff(input int ref_cycles);
    return (ref_cycles < 1) ? 1 : ref_cycles;
  endfunction

  // Observed edges needed so that the reset covers ref_cycles full periods.
  // One observed edge may predate the pulse (synchroniser latency); the next
  // ref_cycles+1 edges then bound ref_cycles whole periods inside it.
  function automatic int rst_edges_needed(input int ref_cycles);
    return rst_cycles_eff(ref_cycles) + 2;
  endfunction

endpackage

// File: rtl/pllseq_refclk_mon.sv
`timescale 1ns/1ps
module pllseq_refclk_mon #(
  parameter int EDGES_MIN = 4,
  parameter int GAP_MAX   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  output logic ref_edge,
  output logic ref_present
);
  localparam int EW = pllseq_pkg::cnt_width(EDGES_MIN);
  localparam int GW = pllseq_pkg::cnt_width(GAP_MAX);

  logic          tog_ref;
  logic [2:0]    sync_q;
  logic [EW-1:0] edge_cnt;
  logic [GW-1:0] gap_cnt;
  logic          gap_expired;

  // Toggle flop in the reference domain
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tog_ref <= 1'b0;
    else        tog_ref <= ~tog_ref;
  end

  // Resynchronise into the system domain; the third stage detects change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tog_ref};
  end

  assign ref_edge    = sync_q[2] ^ sync_q[1];
  assign gap_expired = (gap_cnt == GW'(GAP_MAX));
  assign ref_present = (edge_cnt == EW'(EDGES_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap_cnt <= '0;
    else if (ref_edge)     gap_cnt <= '0;
    else if (!gap_expired) gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       edge_cnt <= '0;
    else if (gap_expired && !ref_edge) edge_cnt <= '0;
    else if (ref_edge && !ref_present) edge_cnt <= edge_cnt + 1'b1;
  end

  // R2
  gap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_expired && !ref_edge) |=> !ref_present);

  // R2
  present_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_present) |-> $past(ref_edge));

endmodule

// File: rtl/pllseq_lock_filter.sv
`timescale 1ns/1ps
module pllseq_lock_filter #(
  parameter int STABLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  input  logic enable,
  output logic lock_sync,
  output logic lock_stable
);
  localparam int CW = pllseq_pkg::cnt_width(STABLE_CYC);

  logic [1:0]    sync_q;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], lock_async};
  end

  assign lock_sync   = sync_q[1];
  assign lock_stable = (hold_cnt == CW'(STABLE_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hold_cnt <= '0;
    else if (!enable || !lock_sync) hold_cnt <= '0;
    else if (!lock_stable)        hold_cnt <= hold_cnt + 1'b1;
  end

  // R6
  glitch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_sync |=> !lock_stable);

  // R6
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !lock_stable);

endmodule

// File: rtl/pllseq_rst_pulse.sv
`timescale 1ns/1ps
module pllseq_rst_pulse #(
  parameter int REF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ref_edge,
  output logic done
);
  localparam int NEED = pllseq_pkg::rst_edges_needed(REF_CYC);
  localparam int PW   = pllseq_pkg::cnt_width(NEED);

  logic [PW-1:0] edge_cnt;

  assign done = (edge_cnt == PW'(NEED));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                edge_cnt <= '0;
    else if (!active)          edge_cnt <= '0;
    else if (ref_edge && !done) edge_cnt <= edge_cnt + 1'b1;
  end

  // R4
  pulse_starts_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !done);

endmodule

// File: rtl/pll_rst_seq.sv
`timescale 1ns/1ps
module pll_rst_seq #(
  parameter int REF_EDGES_MIN = 4,
  parameter int REF_GAP_MAX   = 16,
  parameter int RST_REF_CYC   = 2,
  parameter int LOCK_STABLE   = 8,
  parameter int LOCK_TMO      = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic pll_lock,
  output logic pll_pd,
  output logic pll_rst,
  output logic pll_lock_en,
  output logic seq_ready,
  output logic seq_err
);
  import pllseq_pkg::*;

  localparam int TW = cnt_width(LOCK_TMO);

  seq_state_e    state_q, state_d;
  logic          ref_edge, ref_present;
  logic          lock_sync, lock_stable;
  logic          pulse_done;
  logic [TW-1:0] tmo_cnt;
  logic          tmo_hit;
  logic          lock_lost;
  logic          err_q;

  pllseq_refclk_mon #(
    .EDGES_MIN (REF_EDGES_MIN),
    .GAP_MAX   (REF_GAP_MAX)
  ) u_refmon (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_clk     (ref_clk),
    .ref_edge    (ref_edge),
    .ref_present (ref_present)
  );

  pllseq_rst_pulse #(
    .REF_CYC (RST_REF_CYC)
  ) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (state_q == SEQ_RESET),
    .ref_edge (ref_edge),
    .done     (pulse_done)
  );

  pllseq_lock_filter #(
    .STABLE_CYC (LOCK_STABLE)
  ) u_lockf (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_async  (pll_lock),
    .enable      (pll_lock_en),
    .lock_sync   (lock_sync),
    .lock_stable (lock_stable)
  );

  // Lock-wait timeout
  assign tmo_hit = (state_q == SEQ_WAIT) && !lock_stable &&
                   (tmo_cnt == TW'(LOCK_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tmo_cnt <= '0;
    else if (state_q != SEQ_WAIT) tmo_cnt <= '0;
    else if (!tmo_hit)            tmo_cnt <= tmo_cnt + 1'b1;
  end

  assign lock_lost = (state_q == SEQ_READY) && !lock_sync;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_PWRDN: if (ref_present) state_d = SEQ_RESET;
      SEQ_RESET: if (pulse_done)  state_d = SEQ_WAIT;
      SEQ_WAIT: begin
        if (lock_stable)  state_d = SEQ_READY;
        else if (tmo_hit) state_d = SEQ_RESET;
      end
      SEQ_READY: if (lock_lost) state_d = SEQ_RESET;
      default:   state_d = SEQ_PWRDN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_PWRDN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   err_q <= 1'b0;
    else if (tmo_hit)                             err_q <= 1'b1;
    else if (state_q == SEQ_WAIT && lock_stable)  err_q <= 1'b0;
  end

  assign pll_pd      = (state_q == SEQ_PWRDN);
  assign pll_rst     = (state_q == SEQ_RESET);
  assign pll_lock_en = (state_q == SEQ_WAIT) || (state_q == SEQ_READY);
  assign seq_ready   = (state_q == SEQ_READY);
  assign seq_err     = err_q;

  // R10
  no_pd_rst_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pll_pd && pll_rst));

  // R2
  pd_needs_refclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_pd) |-> $past(ref_present));

  // R3
  pd_release_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_pd) |-> pll_rst);

  // R4
  pulse_ends_on_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> $past(pulse_done));

  // R5
  lock_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_lock_en |-> (!pll_pd && !pll_rst));

  // R6
  ready_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_ready) |-> $past(lock_stable));

  // R7
  timeout_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (seq_err && pll_rst));

  // R8
  err_clears_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_err) |-> seq_ready);

  // R9
  lock_loss_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> (!seq_ready && pll_rst && !pll_pd));

endmodule

// File: tb/pll_rst_seq_tb.sv
`timescale 1ns/1ps
module pll_rst_seq_tb;

  localparam int  TB_EDGES  = 4;
  localparam int  TB_GAP    = 16;
  localparam int  TB_RSTCYC = 2;
  localparam int  TB_STABLE = 8;
  localparam int  TB_TMO    = 200;
  localparam real REF_PER   = 16.0;

  typedef struct packed {
    logic [15:0] dly;       // cycles after reset pulse ends before lock rises
    logic        locks;     // lock is raised at all
    logic        err_mid;   // expected seq_err just before lock rises
    logic        rdy_end;   // expected seq_ready at the end
    logic        err_end;   // expected seq_err at the end
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'd5,   1'b1, 1'b0, 1'b1, 1'b0},
    '{16'd60,  1'b1, 1'b0, 1'b1, 1'b0},
    '{16'd180, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'd230, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'd400, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic pll_lock = 1'b0;
  logic pll_pd, pll_rst, pll_lock_en, seq_ready, seq_err;

  int  checks = 0;
  int  errors = 0;
  int  wd_cnt = 0;
  int  burst_left = 0;
  bit  ref_run = 1'b0;
  int  overlaps = 0;
  int  n_pulses = 0;
  realtime t_rise = 0.0;
  realtime t_rel = 0.0;

  pll_rst_seq #(
    .REF_EDGES_MIN (TB_EDGES),
    .REF_GAP_MAX   (TB_GAP),
    .RST_REF_CYC   (TB_RSTCYC),
    .LOCK_STABLE   (TB_STABLE),
    .LOCK_TMO      (TB_TMO)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_clk     (ref_clk),
    .pll_lock    (pll_lock),
    .pll_pd      (pll_pd),
    .pll_rst     (pll_rst),
    .pll_lock_en (pll_lock_en),
    .seq_ready   (seq_ready),
    .seq_err     (seq_err)
  );

  always #2.5 clk = ~clk;

  // Reference clock: free-running or a counted burst
  always begin
    if (ref_run || burst_left > 0) begin
      #(REF_PER / 2.0) ref_clk = 1'b1;
      #(REF_PER / 2.0) ref_clk = 1'b0;
      if (burst_left > 0) burst_left = burst_left - 1;
    end else begin
      #1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_pulse_end();
    while (pll_rst !== 1'b1) cyc(1);
    while (pll_rst === 1'b1) cyc(1);
  endtask

  task automatic finish_run();
    chk(overlaps == 0, "R10 pd/rst overlap cycles", overlaps, 0);
    chk(n_pulses > 0, "R4 reset pulses measured", n_pulses, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd_cnt, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge rst_n) t_rel = $realtime;
  always @(posedge pll_rst) t_rise = $realtime;

  // R4: pulse width measured in time
  always @(negedge pll_rst) begin
    if (rst_n === 1'b1 && t_rise > t_rel) begin
      n_pulses++;
      chk(($realtime - t_rise) >= TB_RSTCYC * REF_PER, "R4 reset pulse width ns",
          int'($realtime - t_rise), int'(TB_RSTCYC * REF_PER));
    end
  end

  // R3: power-down release brings the reset pulse with it
  always @(negedge pll_pd) begin
    #1;
    if (rst_n === 1'b1) chk(pll_rst === 1'b1, "R3 rst at pd release", pll_rst, 1);
  end

  // R10
  always @(negedge clk) begin
    if (rst_n === 1'b1 && pll_pd === 1'b1 && pll_rst === 1'b1) overlaps++;
  end

  initial begin
    // R1: state held in reset
    cyc(5);
    chk(pll_pd === 1'b1,      "R1 pd in reset", pll_pd, 1);
    chk(pll_rst === 1'b0,     "R1 rst in reset", pll_rst, 0);
    chk(pll_lock_en === 1'b0, "R1 lock_en in reset", pll_lock_en, 0);
    chk(seq_ready === 1'b0,   "R1 ready in reset", seq_ready, 0);
    chk(seq_err === 1'b0,     "R1 err in reset", seq_err, 0);
    rst_n = 1'b1;

    // R2: no reference clock
    cyc(100);
    chk(pll_pd === 1'b1,  "R2 pd held without refclk", pll_pd, 1);
    chk(pll_rst === 1'b0, "R2 no reset without refclk", pll_rst, 0);

    // R2: two short bursts, separated by more than the gap limit
    burst_left = 2;
    cyc(60);
    chk(pll_pd === 1'b1, "R2 pd held after 2 edges", pll_pd, 1);
    burst_left = 2;
    cyc(60);
    chk(pll_pd === 1'b1, "R2 pd held after split edges", pll_pd, 1);

    // R2: steady reference clock
    ref_run = 1'b1;
    cyc(40);
    chk(pll_pd === 1'b0, "R2 pd released with refclk", pll_pd, 0);

    // R5: lock detector enabled only after the pulse
    while (pll_lock_en !== 1'b1) cyc(1);
    chk(pll_rst === 1'b0 && pll_pd === 1'b0, "R5 lock_en alone",
        {pll_pd, pll_rst}, 0);

    // R6: glitched lock, total high time above the window
    pll_lock = 1'b1; cyc(5);
    pll_lock = 1'b0; cyc(2);
    pll_lock = 1'b1; cyc(9);
    chk(seq_ready === 1'b0, "R6 ready early after glitch", seq_ready, 0);
    cyc(5);
    chk(seq_ready === 1'b1, "R6 ready after stable lock", seq_ready, 1);
    chk(seq_err === 1'b0,   "R8 no err on clean lock", seq_err, 0);

    // R9: loss of lock while ready
    pll_lock = 1'b0;
    cyc(4);
    chk(seq_ready === 1'b0,   "R9 ready cleared", seq_ready, 0);
    chk(pll_rst === 1'b1,     "R9 reset reissued", pll_rst, 1);
    chk(pll_pd === 1'b0,      "R9 pd stays low", pll_pd, 0);
    chk(pll_lock_en === 1'b0, "R5 lock_en off in pulse", pll_lock_en, 0);
    pll_lock = 1'b1;
    cyc(40);
    chk(seq_ready === 1'b1, "R9 relock after loss", seq_ready, 1);

    // Lock-delay vectors (R6, R7, R8)
    foreach (VECS[i]) begin
      pll_lock = 1'b0;
      rst_n = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      wait_pulse_end();
      cyc(int'(VECS[i].dly));
      chk(seq_err === VECS[i].err_mid, "R7 err before lock", seq_err, VECS[i].err_mid);
      if (VECS[i].locks) pll_lock = 1'b1;
      cyc(9);
      chk(seq_ready === 1'b0, "R6 ready not before window", seq_ready, 0);
      cyc(50);
      chk(seq_ready === VECS[i].rdy_end, "R6 ready at end", seq_ready, VECS[i].rdy_end);
      chk(seq_err === VECS[i].err_end, "R8 err at end", seq_err, VECS[i].err_end);
    end

    finish_run();
  end

endmodule